// File: doc/BRIEF.md
# Windowed Watchdog with Two-Byte Service Sequence

This block is a watchdog timer that runs on the oscillator clock. Software writes a control register to choose one of seven timeout lengths. Writing any nonzero rate starts the first period. To keep the watchdog from expiring, software services it with a two-byte key: 0x55 followed by 0xAA, both written to a separate arm register. If the count reaches the selected length, or software services the watchdog incorrectly, the block raises a one-cycle reset request. Sequencing that request into a system reset is left to the surrounding logic.

An optional window mode makes servicing stricter: an arm write is accepted only in the final quarter of the period. The counter also obeys the chip's low-power and debug states. It can clear and hold while the chip waits, and it can freeze in place during pseudo-stop or while a debugger is active. The hold-in-wait control bit can be written only once in normal mode. In special mode it can be written any number of times.

For simulation, a parameter `SCALE_DN` shortens every timeout by the same power of two. The default of 0 gives the full lengths.

Top module: `wdog_window`

## Requirements
- R1: With a rate code of 0 the watchdog is off. It never raises `rst_req`, and arm-register writes are ignored.
- R2: The control register sits at `wr_addr`=0, with rate in bits [2:0], window enable in bit 7, freeze-in-debug in bit 6 and hold-in-wait in bit 5. Each control write restarts the count from 0. The period length L depends on the rate code, 1 through 7, and is 2^(14,16,18,20,22,23,24 − `SCALE_DN`). `rst_req` goes high in the L-th cycle after the control write edge.
- R3: `rst_req` lasts exactly one cycle. Every request restarts the count from 0 and clears any pending 0x55.
- R4: The arm register sits at `wr_addr`=1. Writing 0x55 and then 0xAA restarts the count from 0.
- R5: Writing 0xAA with no 0x55 pending has no effect, and the count continues.
- R6: While the watchdog is enabled, writing any value other than 0x55 or 0xAA to the arm register raises `rst_req` in the next cycle.
- R7: In window mode, an arm write made while the count is below 3L/4 raises `rst_req`. An arm write at a count of 3L/4 or above is accepted.
- R8: In window mode, 0x55 may be repeated inside the window. After 0xAA completes a service, the next arm write falls before the new window and raises `rst_req`.
- R9: While `wait_mode` is high and hold-in-wait is set, the count is cleared and held at 0, and any pending 0x55 is dropped. If hold-in-wait is clear, `wait_mode` has no effect.
- R10: When `special_mode` is 0, only the first control write can change hold-in-wait. When `special_mode` is 1, every control write can change it.
- R11: While `pstop_mode` is high and `pstop_run_en` is low, the count freezes and keeps its value. If `pstop_run_en` is high, it keeps counting.
- R12: While `debug_mode` is high and freeze-in-debug is set, the count freezes and keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the control register, 1 selects the arm register |
| wr_data | input | 8 | Write data |
| special_mode | input | 1 | High in special mode, low in normal mode |
| wait_mode | input | 1 | Chip is in wait mode |
| pstop_mode | input | 1 | Chip is in pseudo-stop |
| pstop_run_en | input | 1 | Keep counting during pseudo-stop |
| debug_mode | input | 1 | Debugger is active |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A control write or a completed service clears the count on its clock edge. From there a timeout request appears exactly L edges later. The bench therefore waits L−1 cycles, checks that `rst_req` is still low, and then checks that it is high on the next cycle and low on the one after. A rejected arm write registers its request on the same edge that samples the write, so the bench checks `rst_req` at the falling edge that ends the write. For an arm write, the count it is judged against equals the number of cycles that have passed since the count was cleared. The window tests place their writes at counts 3L/4−1 and 3L/4 to exercise that boundary. Freeze and hold tests predict the cycles left before timeout from the count at entry and check that the request arrives on exactly that cycle.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int SCALE_DN = 0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       special_mode,
  input  logic       wait_mode,
  input  logic       pstop_mode,
  input  logic       pstop_run_en,
  input  logic       debug_mode,
  output logic       rst_req
);
  localparam int CW = 25;

  logic [2:0]    rate_q;
  logic          win_q, dfrz_q, halt_q, lock_q, armed_q;
  logic [CW-1:0] cnt_q, lim;
  int            expo;

  always_comb begin
    case (rate_q)
      3'd1:    expo = 14;
      3'd2:    expo = 16;
      3'd3:    expo = 18;
      3'd4:    expo = 20;
      3'd5:    expo = 22;
      3'd6:    expo = 23;
      3'd7:    expo = 24;
      default: expo = 14;
    endcase
    lim = CW'(1) << (expo - SCALE_DN);
  end

  wire en       = rate_q != 3'd0;
  wire ctl_wr   = wr_en && !wr_addr;
  wire arm_wr   = wr_en && wr_addr && en;
  wire is55     = wr_data == 8'h55;
  wire isAA     = wr_data == 8'hAA;
  wire win_open = cnt_q >= (lim - (lim >> 2));
  wire bad      = arm_wr && (!(is55 || isAA) || (win_q && !win_open));
  wire refresh  = arm_wr && !bad && isAA && armed_q;
  wire halt     = wait_mode && halt_q;
  wire frz      = (pstop_mode && !pstop_run_en) || (debug_mode && dfrz_q);
  wire tout     = en && !halt && !frz && (cnt_q == lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q  <= '0;
      win_q   <= 1'b0;
      dfrz_q  <= 1'b0;
      halt_q  <= 1'b0;
      lock_q  <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= bad || (tout && !refresh && !ctl_wr);
      if (ctl_wr) begin
        rate_q  <= wr_data[2:0];
        win_q   <= wr_data[7];
        dfrz_q  <= wr_data[6];
        if (special_mode || !lock_q) halt_q <= wr_data[5];
        if (!special_mode) lock_q <= 1'b1;
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else if (!en || bad || refresh || halt || tout) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        if (arm_wr && is55) armed_q <= 1'b1;
        if (!frz) cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 3'd0) |=> !rst_req);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q < lim));
  // R3
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt_q == '0 && !armed_q));
  // R6
  junk_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && !is55 && !isAA) |=> rst_req);
  // R7
  early_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && win_q && !win_open) |=> rst_req);
  // R9
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wait_mode && halt_q && !wr_en) |=> (cnt_q == '0));
  // R10
  once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !special_mode && lock_q) |=> $stable(halt_q));
  // R11 R12
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frz && !halt && !wr_en) |=> $stable(cnt_q));
endmodule

// File: tb/sim_wdog_window.sv
`timescale 1ns/1ps
module sim_wdog_window;
  logic clk = 0, rst_n = 0, wr_en = 0, wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic special_mode = 0, wait_mode = 0, pstop_mode = 0, pstop_run_en = 0, debug_mode = 0;
  logic rst_req;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  wdog_window #(.SCALE_DN(10)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .special_mode(special_mode), .wait_mode(wait_mode), .pstop_mode(pstop_mode),
    .pstop_run_en(pstop_run_en), .debug_mode(debug_mode), .rst_req(rst_req));

  task automatic check(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; wait_mode = 0; pstop_mode = 0; pstop_run_en = 0; debug_mode = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic bus_wr(logic a, logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic no_req(int n, string req);
    int seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (rst_req) seen++; end
    check(seen == 0, req, seen, 0);
  endtask

  task automatic expect_timeout(int n, string req);
    no_req(n - 1, req);
    @(negedge clk);
    check(rst_req == 1, req, rst_req, 1);
    @(negedge clk);
    check(rst_req == 0, {req, " R3 pulse"}, rst_req, 0);
  endtask

  task automatic t_reset_off();
    do_reset();
    check(rst_req == 0, "R1 reset", rst_req, 0);
    no_req(200, "R1 idle");
    bus_wr(1, 8'h12);
    check(rst_req == 0, "R1 arm ignored", rst_req, 0);
    bus_wr(0, 8'h01);
    wait_n(8);
    bus_wr(0, 8'h00);
    no_req(100, "R1 disabled mid-count");
  endtask

  task automatic t_rates();
    do_reset();
    bus_wr(0, 8'h01);
    expect_timeout(16, "R2 rate1");
    do_reset();
    bus_wr(0, 8'h01);
    expect_timeout(16, "R3 first");
    expect_timeout(15, "R3 repeat");
    do_reset();
    bus_wr(0, 8'h02);
    expect_timeout(64, "R2 rate2");
    do_reset();
    bus_wr(0, 8'h06);
    expect_timeout(8192, "R2 rate6");
    do_reset();
    bus_wr(0, 8'h07);
    expect_timeout(16384, "R2 rate7");
  endtask

  task automatic t_service();
    do_reset();
    bus_wr(0, 8'h01);
    wait_n(10);
    bus_wr(1, 8'h55);
    bus_wr(1, 8'hAA);
    check(rst_req == 0, "R4 service", rst_req, 0);
    expect_timeout(16, "R4 restart");
    do_reset();
    bus_wr(0, 8'h01);
    wait_n(5);
    bus_wr(1, 8'hAA);
    expect_timeout(10, "R5 lone AA");
  endtask

  task automatic t_bad_value();
    do_reset();
    bus_wr(0, 8'h01);
    wait_n(3);
    bus_wr(1, 8'h12);
    check(rst_req == 1, "R6 bad value", rst_req, 1);
    @(negedge clk);
    expect_timeout(15, "R3 after bad");
  endtask

  task automatic t_window();
    do_reset();
    bus_wr(0, 8'h81);
    wait_n(11);
    bus_wr(1, 8'h55);
    check(rst_req == 1, "R7 early", rst_req, 1);
    do_reset();
    bus_wr(0, 8'h81);
    wait_n(12);
    bus_wr(1, 8'h55);
    check(rst_req == 0, "R7 in window", rst_req, 0);
    bus_wr(1, 8'h55);
    check(rst_req == 0, "R8 repeat 55", rst_req, 0);
    bus_wr(1, 8'hAA);
    check(rst_req == 0, "R8 AA", rst_req, 0);
    bus_wr(1, 8'h55);
    check(rst_req == 1, "R8 after service", rst_req, 1);
  endtask

  task automatic t_wait();
    do_reset();
    special_mode = 1;
    bus_wr(0, 8'h21);
    wait_n(10);
    wait_mode = 1;
    no_req(30, "R9 held");
    wait_mode = 0;
    expect_timeout(16, "R9 after wait");
    do_reset();
    bus_wr(0, 8'h01);
    wait_n(5);
    wait_mode = 1;
    wait_n(5);
    wait_mode = 0;
    expect_timeout(6, "R9 no hold");
    special_mode = 0;
  endtask

  task automatic t_once();
    do_reset();
    special_mode = 0;
    bus_wr(0, 8'h01);
    bus_wr(0, 8'h21);
    wait_n(4);
    wait_mode = 1;
    wait_n(4);
    wait_mode = 0;
    expect_timeout(8, "R10 locked");
    special_mode = 1;
    bus_wr(0, 8'h21);
    wait_n(4);
    wait_mode = 1;
    wait_n(4);
    wait_mode = 0;
    expect_timeout(16, "R10 special");
    special_mode = 0;
  endtask

  task automatic t_freeze();
    do_reset();
    bus_wr(0, 8'h01);
    wait_n(6);
    pstop_mode = 1; pstop_run_en = 0;
    no_req(20, "R11 frozen");
    pstop_mode = 0;
    expect_timeout(10, "R11 resume");
    do_reset();
    bus_wr(0, 8'h01);
    wait_n(6);
    pstop_mode = 1; pstop_run_en = 1;
    wait_n(5);
    pstop_mode = 0;
    expect_timeout(5, "R11 run enabled");
    do_reset();
    bus_wr(0, 8'h41);
    wait_n(6);
    debug_mode = 1;
    no_req(20, "R12 frozen");
    debug_mode = 0;
    expect_timeout(10, "R12 resume");
    do_reset();
    bus_wr(0, 8'h01);
    wait_n(6);
    debug_mode = 1;
    wait_n(4);
    debug_mode = 0;
    expect_timeout(6, "R12 bit clear");
  endtask

  initial begin
    #(150000 * 10);
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset_off();
    t_rates();
    t_service();
    t_bad_value();
    t_window();
    t_wait();
    t_once();
    t_freeze();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule